// File: doc/BRIEF.md
# Sum-of-Products Logic Cell

This block is one configurable logic cell of the kind tiled many times inside a small programmable logic device. A shared input bus is the concatenation of a global bus and a regional bus. Five AND terms are formed over any chosen literals of that bus. A set of static configuration bits steers each term to one of three roles: the OR sum, the second operand of a polarity XOR, or the register data input. A term can also be switched off.

The OR sum is merged with a cascade input from the neighbouring cell, and the merged value is passed on as the cascade output. Wider sums are built by chaining cells in this way: eight cells give forty terms. The XOR stage inverts or passes the sum, mixes in a term, or folds the register's own state back so that the register behaves as a toggle flip-flop. The register takes either the XOR result or its own dedicated terms. The pin output shows the register or the combinational XOR result. The register state is always present on the feedback output, so a combinational pin can sit alongside a buried register.

Configuration inputs are treated as static. Loading them is the job of the surrounding fabric.

Top module: `pld_macrocell`

## Requirements
- R1: Literal code per input and term is 2 bits at `lit_cfg_i[(t*IN_W+i)*2 +: 2]`: 1 = true input, 2 = complemented input, 0 or 3 = unused. A term is the AND of its used literals, and a term with no used literal is 1. Bus index i below GLB_W is `glb_i[i]`; the rest is `rgn_i[i-GLB_W]`.
- R2: Role code per term is 2 bits at `role_cfg_i[t*2 +: 2]`: 0 = off, 1 = OR sum, 2 = XOR operand, 3 = register data. An off term has no effect on any output, even when it evaluates to 1.
- R3: The sum is the OR of all sum-role terms and `casc_i`. `casc_o` equals that sum combinationally.
- R4: Eight cells chained from `casc_o` to `casc_i` form one 40-term OR at the last cell's `casc_o`.
- R5: `xsrc_cfg_i` selects the second XOR operand: 0 = constant 0, 1 = constant 1, 2 = OR of XOR-role terms, 3 = current register value. The XOR result is the sum XOR that operand.
- R6: With `osel_cfg_i`=0, `pin_o` shows the XOR result combinationally. Operand 0 passes the sum, and operand 1 inverts it.
- R7: At a rising clock edge with `ce_i`=1, the register loads the XOR result when `dsrc_cfg_i`=0, or the OR of register-role terms when `dsrc_cfg_i`=1.
- R8: `fb_o` always shows the register, whatever `osel_cfg_i` is.
- R9: With operand 3 and data source 0, the register inverts on each enabled edge where the sum is 1, and holds where it is 0.
- R10: With `ce_i`=0, the register holds its value across clock edges.
- R11: `rst_ni` low clears the register to 0 at once, without waiting for a clock edge.
- R12: With `osel_cfg_i`=1, `pin_o` shows the register. `oe_o` follows `oe_cfg_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Register clock enable |
| glb_i | input | GLB_W | Global input bus |
| rgn_i | input | RGN_W | Regional input bus |
| lit_cfg_i | input | NUM_PT*IN_W*2 | Literal codes for every term |
| role_cfg_i | input | NUM_PT*2 | Role code for every term |
| xsrc_cfg_i | input | 2 | XOR second operand select |
| dsrc_cfg_i | input | 1 | Register data source select |
| osel_cfg_i | input | 1 | Pin source: 0 combinational, 1 register |
| oe_cfg_i | input | 1 | Output enable setting |
| casc_i | input | 1 | Cascade sum from the neighbouring cell |
| casc_o | output | 1 | Cascade sum to the next cell |
| pin_o | output | 1 | Cell output |
| oe_o | output | 1 | Output enable |
| fb_o | output | 1 | Register feedback |

## Verification
The bench sweeps a reference model over hundreds of random configurations and input words, covering every role and operand choice. A term that is switched off but evaluates to 1 leaks into the sum if the role mask is wrong. An empty term reads 0 instead of 1 if the AND starts from the wrong identity. The toggle path is driven with a constant-1 sum: a design that loads the sum instead of sum XOR state stays at 1, and a design that ignores the clock enable keeps toggling. Eight cells are chained with one distinct minterm per term, and every bus value is swept. A break anywhere in the chain drops a range of codes out of the 40-entry set, and a polarity fault inverts the whole range.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;
  typedef enum logic [1:0] {LIT_OFF = 2'd0, LIT_TRUE = 2'd1, LIT_INV = 2'd2, LIT_NONE = 2'd3} lit_e;
  typedef enum logic [1:0] {ROLE_OFF = 2'd0, ROLE_SUM = 2'd1, ROLE_XOR = 2'd2, ROLE_REG = 2'd3} role_e;
  typedef enum logic [1:0] {XS_ZERO = 2'd0, XS_ONE = 2'd1, XS_TERM = 2'd2, XS_TOGGLE = 2'd3} xsrc_e;
endpackage

// File: rtl/mc_pterm.sv
module mc_pterm import macrocell_pkg::*; #(
  parameter int IN_W = 8
) (
  input  logic [IN_W-1:0]   bus_i,
  input  logic [2*IN_W-1:0] lit_i,
  output logic              term_o
);
  logic [IN_W-1:0] hit;

  for (genvar i = 0; i < IN_W; i++) begin : g_lit
    lit_e code;
    assign code = lit_e'(lit_i[2*i +: 2]);
    always_comb begin
      unique case (code)
        LIT_TRUE: hit[i] = bus_i[i];
        LIT_INV:  hit[i] = ~bus_i[i];
        default:  hit[i] = 1'b1;
      endcase
    end
  end

  assign term_o = &hit;
endmodule

// File: rtl/mc_ptmux.sv
module mc_ptmux import macrocell_pkg::*; #(
  parameter int NUM_PT = 5
) (
  input  logic [NUM_PT-1:0]   term_i,
  input  logic [2*NUM_PT-1:0] role_i,
  output logic                sum_o,
  output logic                xor_o,
  output logic                reg_o
);
  logic [NUM_PT-1:0] to_sum, to_xor, to_reg;

  for (genvar t = 0; t < NUM_PT; t++) begin : g_route
    role_e r;
    assign r         = role_e'(role_i[2*t +: 2]);
    assign to_sum[t] = term_i[t] && (r == ROLE_SUM);
    assign to_xor[t] = term_i[t] && (r == ROLE_XOR);
    assign to_reg[t] = term_i[t] && (r == ROLE_REG);
  end

  assign sum_o = |to_sum;
  assign xor_o = |to_xor;
  assign reg_o = |to_reg;
endmodule

// File: rtl/mc_reg.sv
module mc_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (ce_i) q_o <= d_i;
  end

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> (q_o == $past(q_o)));
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell import macrocell_pkg::*; #(
  parameter int GLB_W  = 4,
  parameter int RGN_W  = 4,
  parameter int NUM_PT = 5,
  localparam int IN_W  = GLB_W + RGN_W,
  localparam int LIT_W = NUM_PT * IN_W * 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic [GLB_W-1:0]   glb_i,
  input  logic [RGN_W-1:0]   rgn_i,
  input  logic [LIT_W-1:0]   lit_cfg_i,
  input  logic [2*NUM_PT-1:0] role_cfg_i,
  input  logic [1:0]         xsrc_cfg_i,
  input  logic               dsrc_cfg_i,
  input  logic               osel_cfg_i,
  input  logic               oe_cfg_i,
  input  logic               casc_i,
  output logic               casc_o,
  output logic               pin_o,
  output logic               oe_o,
  output logic               fb_o
);
  logic [IN_W-1:0]   bus;
  logic [NUM_PT-1:0] pt;
  logic sum_pt, xor_pt, reg_pt, sum, xop, xo, d, q;

  assign bus = {rgn_i, glb_i};

  for (genvar t = 0; t < NUM_PT; t++) begin : g_pt
    mc_pterm #(.IN_W(IN_W)) u_pt (
      .bus_i  (bus),
      .lit_i  (lit_cfg_i[t*2*IN_W +: 2*IN_W]),
      .term_o (pt[t])
    );
  end

  mc_ptmux #(.NUM_PT(NUM_PT)) u_mux (
    .term_i (pt),
    .role_i (role_cfg_i),
    .sum_o  (sum_pt),
    .xor_o  (xor_pt),
    .reg_o  (reg_pt)
  );

  assign sum = sum_pt | casc_i;

  always_comb begin
    unique case (xsrc_e'(xsrc_cfg_i))
      XS_ZERO: xop = 1'b0;
      XS_ONE:  xop = 1'b1;
      XS_TERM: xop = xor_pt;
      default: xop = q;
    endcase
  end

  assign xo = sum ^ xop;
  assign d  = dsrc_cfg_i ? reg_pt : xo;

  mc_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .d_i    (d),
    .q_o    (q)
  );

  assign casc_o = sum;
  assign pin_o  = osel_cfg_i ? q : xo;
  assign oe_o   = oe_cfg_i;
  assign fb_o   = q;

  assert_casc_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_i |-> casc_o);
  assert_polarity_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osel_cfg_i && xsrc_cfg_i == 2'd1) |-> (pin_o != casc_o));
  assert_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && xsrc_cfg_i == 2'd3 && !dsrc_cfg_i && casc_o) |=> (fb_o != $past(fb_o)));
  assert_reg_pin_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osel_cfg_i |-> (pin_o == fb_o));
endmodule

// File: tb/pld_macrocell_test.sv
module pld_macrocell_test;
  localparam int CLK_PERIOD = 10;
  localparam int GLB_W = 4, RGN_W = 4, NUM_PT = 5;
  localparam int IN_W = GLB_W + RGN_W;
  localparam int LIT_W = NUM_PT * IN_W * 2;
  localparam int NCH = 8;

  logic clk = 1'b0, rst_ni = 1'b0, ce = 1'b0;
  logic [IN_W-1:0] bus = '0;
  logic [LIT_W-1:0] lit = '0;
  logic [2*NUM_PT-1:0] role = '0;
  logic [1:0] xsrc = '0;
  logic dsrc = 1'b0, osel = 1'b0, oe = 1'b0, casc_in = 1'b0;
  logic casc_out, pin, oe_out, fb;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic q_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  pld_macrocell #(.GLB_W(GLB_W), .RGN_W(RGN_W), .NUM_PT(NUM_PT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce),
    .glb_i(bus[GLB_W-1:0]), .rgn_i(bus[IN_W-1:GLB_W]),
    .lit_cfg_i(lit), .role_cfg_i(role), .xsrc_cfg_i(xsrc),
    .dsrc_cfg_i(dsrc), .osel_cfg_i(osel), .oe_cfg_i(oe),
    .casc_i(casc_in), .casc_o(casc_out), .pin_o(pin), .oe_o(oe_out), .fb_o(fb)
  );

  // eight-cell chain, one minterm per term
  logic [IN_W-1:0] ch_bus = '0;
  logic [LIT_W-1:0] ch_lit [NCH];
  logic [1:0] ch_xsrc = '0;
  logic [NCH:0] ch_casc;
  logic [NCH-1:0] ch_pin, ch_oe, ch_fb;
  assign ch_casc[0] = 1'b0;

  for (genvar c = 0; c < NCH; c++) begin : g_chain
    pld_macrocell #(.GLB_W(GLB_W), .RGN_W(RGN_W), .NUM_PT(NUM_PT)) u_cell (
      .clk_i(clk), .rst_ni(rst_ni), .ce_i(1'b0),
      .glb_i(ch_bus[GLB_W-1:0]), .rgn_i(ch_bus[IN_W-1:GLB_W]),
      .lit_cfg_i(ch_lit[c]), .role_cfg_i({NUM_PT{2'd1}}), .xsrc_cfg_i(ch_xsrc),
      .dsrc_cfg_i(1'b0), .osel_cfg_i(1'b0), .oe_cfg_i(1'b0),
      .casc_i(ch_casc[c]), .casc_o(ch_casc[c+1]), .pin_o(ch_pin[c]),
      .oe_o(ch_oe[c]), .fb_o(ch_fb[c])
    );
  end

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic term_m(input logic [2*IN_W-1:0] l, input logic [IN_W-1:0] b);
    logic r = 1'b1;
    for (int i = 0; i < IN_W; i++) begin
      if (l[2*i +: 2] == 2'd1 && !b[i]) r = 1'b0;
      if (l[2*i +: 2] == 2'd2 &&  b[i]) r = 1'b0;
    end
    return r;
  endfunction

  logic sum_m, xo_m, d_m;
  task automatic model();
    logic s = casc_in, xt = 1'b0, rt = 1'b0, op;
    for (int t = 0; t < NUM_PT; t++) begin
      logic v = term_m(lit[t*2*IN_W +: 2*IN_W], bus);
      case (role[2*t +: 2])
        2'd1: s  = s  | v;
        2'd2: xt = xt | v;
        2'd3: rt = rt | v;
        default: ;
      endcase
    end
    case (xsrc)
      2'd0: op = 1'b0;
      2'd1: op = 1'b1;
      2'd2: op = xt;
      default: op = q_m;
    endcase
    sum_m = s;
    xo_m  = s ^ op;
    d_m   = dsrc ? rt : xo_m;
  endtask

  function automatic logic [1:0] rnd_lit();
    if ($urandom % 3 != 0) return 2'd0;
    return ($urandom % 2) ? 2'd1 : 2'd2;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    osel = 1'b1;
    #(2*CLK_PERIOD + 1);
    chk(fb == 1'b0, "R11 reset fb", fb, 1'b0);
    chk(pin == 1'b0, "R11 reset pin", pin, 1'b0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    q_m = 1'b0;

    // R1/R2: a single sum term over every bus value
    osel = 1'b0;
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < IN_W; i++) lit[2*i +: 2] = rnd_lit();
      role = {{(NUM_PT-1){2'd0}}, 2'd1};
      for (int b = 0; b < (1 << IN_W); b++) begin
        bus = b[IN_W-1:0];
        #1;
        chk(casc_out == term_m(lit[2*IN_W-1:0], bus), "R1 term", casc_out,
            term_m(lit[2*IN_W-1:0], bus));
      end
    end
    lit = '0; bus = 8'h5A; role = '0;
    #1;
    chk(casc_out == 1'b0, "R2 off term ignored", casc_out, 1'b0);
    role = {{(NUM_PT-1){2'd0}}, 2'd1};
    #1;
    chk(casc_out == 1'b1, "R1 empty term is 1", casc_out, 1'b1);
    role = 10'b11_10_11_10_00; xsrc = 2'd0; dsrc = 1'b0; osel = 1'b0;
    #1;
    chk(pin == 1'b0, "R2 off term no pin effect", pin, 1'b0);

    // random sweep against the model
    @(posedge clk); #1;
    for (int k = 0; k < 600; k++) begin
      for (int j = 0; j < NUM_PT*IN_W; j++) lit[2*j +: 2] = rnd_lit();
      role = 10'($urandom); xsrc = 2'($urandom); dsrc = 1'($urandom);
      osel = 1'($urandom); oe = 1'($urandom); casc_in = ($urandom % 4 == 0);
      ce = ($urandom % 4 != 0); bus = 8'($urandom);
      model();
      #1;
      chk(casc_out == sum_m, "R3 sum/cascade", casc_out, sum_m);
      if (osel) chk(pin == q_m, "R12 registered pin", pin, q_m);
      else      chk(pin == xo_m, "R5 xor result on pin", pin, xo_m);
      chk(oe_out == oe, "R12 output enable", oe_out, oe);
      chk(fb == q_m, "R8 feedback", fb, q_m);
      if (ce) q_m = d_m;
      @(posedge clk); #1;
      chk(fb == q_m, "R7 register load", fb, q_m);
    end
    ce = 1'b0; casc_in = 1'b0; oe = 1'b0;

    // R11: asynchronous clear between edges
    rst_ni = 1'b0;
    #1;
    chk(fb == 1'b0, "R11 async clear", fb, 1'b0);
    rst_ni = 1'b1;

    // R9: toggle with constant-1 sum
    lit = '0; role = {{(NUM_PT-1){2'd0}}, 2'd1};
    xsrc = 2'd3; dsrc = 1'b0; osel = 1'b0; ce = 1'b1;
    q_m = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      q_m = ~q_m;
      chk(fb == q_m, "R9 toggle", fb, q_m);
      chk(pin == ~q_m, "R9 comb sum xor state", pin, ~q_m);
    end
    ce = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1;
      chk(fb == q_m, "R10 enable low hold", fb, q_m);
    end
    role = '0; ce = 1'b1;
    @(posedge clk); #1;
    chk(fb == q_m, "R9 sum 0 holds", fb, q_m);

    // buried register: register-term data, combinational pin
    role = {{(NUM_PT-1){2'd0}}, 2'd3}; dsrc = 1'b1; xsrc = 2'd0; osel = 1'b0;
    @(posedge clk); #1;
    chk(fb == 1'b1, "R8 buried register", fb, 1'b1);
    chk(pin == 1'b0, "R6 comb pin passes sum", pin, 1'b0);
    ce = 1'b0;

    // R4: eight-cell chain, codes 0..39 hit
    for (int c = 0; c < NCH; c++)
      for (int t = 0; t < NUM_PT; t++)
        for (int i = 0; i < IN_W; i++)
          ch_lit[c][(t*IN_W+i)*2 +: 2] = (((c*NUM_PT+t) >> i) & 1) ? 2'd1 : 2'd2;
    for (int xs = 0; xs < 2; xs++) begin
      ch_xsrc = 2'(xs);
      for (int b = 0; b < (1 << IN_W); b++) begin
        logic e;
        ch_bus = b[IN_W-1:0];
        #1;
        e = (b < NCH*NUM_PT);
        chk(ch_casc[NCH] == e, "R4 chained sum", ch_casc[NCH], e);
        chk(ch_pin[NCH-1] == (e ^ xs[0]), "R6 polarity", ch_pin[NCH-1], e ^ xs[0]);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule